// File: doc/BRIEF.md
# Prescaled Dual Pacer Timer

This block paces sampling for an acquisition front end. It produces two single-cycle strobes. The scan strobe marks the start of each scan. The convert strobe marks each conversion inside a scan. Each strobe has its own period, set by a 4-bit prescale and a 16-bit divider that count whole base ticks. The convert timer ticks at half the length of the scan tick: 50 ns against 100 ns at the default 200 MHz clock.

Software loads six parameter slots through a plain write port, then pulses `start`. Only the internally retriggered trigger mode runs. In that mode, each scan strobe starts a counted burst of convert strobes, one for each channel in the list. The burst ends after the programmed count. The next scan strobe starts a fresh burst. `stop` returns the block to idle at once.

All pins are plain control and strobe pins. No data stream passes through the block, so no pin uses back-pressure.

Top module: `dual_pacer`

## Requirements
- R1: While reset is held and after it is released, both strobes stay low until a run is started.
- R2: A write with `prm_wr` high stores `prm_data` into the slot selected by `prm_slot`. The slots are: 0 = conversions per scan, 1 = convert prescale (bits 3:0), 2 = convert divider, 3 = scan prescale (bits 3:0), 4 = scan divider, 5 = mode word. A start copies all stored values into the running settings.
- R3: With scan prescale p and divider d, the scan period is Ps = SCAN_TICK_CYC·(p+1)·d clock cycles. The first scan strobe is high Ps cycles after the clock edge that accepted `start`, and a strobe follows every Ps cycles after that. Each strobe lasts one cycle.
- R4: A divider value of 0 in either timer behaves as a divider of 1.
- R5: After each scan strobe, a convert strobe fires at 1·Pc, 2·Pc … N·Pc cycles after it. Pc = CONV_TICK_CYC·(p+1)·d uses the convert settings, and N is the slot 0 count. There are exactly N convert strobes per scan, none when N is 0, and none before the first scan strobe.
- R6: A scan strobe that arrives before a burst has finished restarts the burst count and the convert timer. A convert strobe due on the same cycle as that scan strobe is still emitted.
- R7: A start is accepted only when bits 4:2 of the mode word equal 2 (internal retriggered). Codes 0, 1, 3, 4 and all others leave the block idle with no strobes. The other bits of the mode word have no effect.
- R8: A `start` pulse during a run has no effect on strobe timing.
- R9: Parameter writes during a run do not change the run in progress. They take effect at the next start.
- R10: No strobe is high in the cycle after the edge that samples `stop`, and none follows until a new start. When `start` and `stop` are high together, the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prm_wr | input | 1 | Parameter slot write enable |
| prm_slot | input | 3 | Parameter slot index |
| prm_data | input | 16 | Parameter write data |
| start | input | 1 | Begin pacing with the stored settings |
| stop | input | 1 | Return to idle |
| cnv_stb | output | 1 | Per-conversion strobe, one cycle |
| scn_stb | output | 1 | Per-scan strobe, one cycle |

## Verification
The bench builds the block with CONV_TICK_CYC = 2 and SCAN_TICK_CYC = 3. This shrinks every period to a few cycles, so a sweep can cover every combination of prescale 0 to 1, divider 0 to 3, scan divider 0 and 3, and count 0 to 3. Those combinations include divider zero, bursts that overrun the scan period, and the exact-fit case where the last convert coincides with the next scan strobe. Each cycle of each run is compared against arithmetic strobe times. Separate runs cover the idle mode codes, start and parameter writes during a run, and start together with stop.

// File: rtl/pacer_pkg.sv
`timescale 1ns/1ps
package pacer_pkg;
  localparam int WORD_W   = 16;
  localparam int PRE_W    = 4;
  localparam int DIV_W    = 16;
  localparam int SLOT_W   = 3;
  localparam int MODE_LSB = 2;
  localparam int MODE_W   = 3;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_COUNT = 3'd0,
    SLOT_CPRE  = 3'd1,
    SLOT_CDIV  = 3'd2,
    SLOT_SPRE  = 3'd3,
    SLOT_SDIV  = 3'd4,
    SLOT_MODE  = 3'd5
  } slot_e;

  typedef enum logic [MODE_W-1:0] {
    TRG_INT     = 3'd0,
    TRG_EXT     = 3'd1,
    TRG_INT_RT  = 3'd2,
    TRG_EXT_RT  = 3'd3,
    TRG_INT_RT2 = 3'd4
  } trig_e;

  typedef struct packed {
    logic [WORD_W-1:0] count;
    logic [PRE_W-1:0]  cpre;
    logic [DIV_W-1:0]  cdiv;
    logic [PRE_W-1:0]  spre;
    logic [DIV_W-1:0]  sdiv;
  } pacer_cfg_t;
endpackage

// File: rtl/pacer_regs.sv
`timescale 1ns/1ps
// Parameter slots: a staged copy written by software and a running copy
// taken on an accepted start.
module pacer_regs import pacer_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              capture,
  output pacer_cfg_t        act_cfg,
  output logic [MODE_W-1:0] mode_field
);
  pacer_cfg_t stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q    <= '0;
      mode_field <= '0;
    end else if (wr_en) begin
      case (wr_slot)
        SLOT_COUNT: stage_q.count <= wr_data;
        SLOT_CPRE:  stage_q.cpre  <= wr_data[PRE_W-1:0];
        SLOT_CDIV:  stage_q.cdiv  <= wr_data[DIV_W-1:0];
        SLOT_SPRE:  stage_q.spre  <= wr_data[PRE_W-1:0];
        SLOT_SDIV:  stage_q.sdiv  <= wr_data[DIV_W-1:0];
        SLOT_MODE:  mode_field    <= wr_data[MODE_LSB +: MODE_W];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       act_cfg <= '0;
    else if (capture) act_cfg <= stage_q;
  end
endmodule

// File: rtl/pacer_div.sv
`timescale 1ns/1ps
// Three cascaded counters: base tick, prescale, divider. fire is high in
// the last cycle of each period, so the period is TICK_CYC*(pre+1)*max(div,1).
module pacer_div #(
  parameter int TICK_CYC = 10,
  parameter int PRE_W    = 4,
  parameter int DIV_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [PRE_W-1:0] pre,
  input  logic [DIV_W-1:0] div,
  output logic             fire
);
  localparam int TICK_W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [TICK_W-1:0] TICK_END = TICK_W'(TICK_CYC - 1);

  logic [TICK_W-1:0] tick_q;
  logic [PRE_W-1:0]  pre_q;
  logic [DIV_W-1:0]  div_q;
  logic [DIV_W-1:0]  div_end;
  logic              tick_last, pre_last, div_last;

  always_comb begin
    div_end   = (div == '0) ? '0 : div - DIV_W'(1);
    tick_last = (tick_q == TICK_END);
    pre_last  = (pre_q == pre);
    div_last  = (div_q == div_end);
    fire      = en & tick_last & pre_last & div_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      tick_q <= '0;
      pre_q  <= '0;
      div_q  <= '0;
    end else if (en) begin
      if (tick_last) begin
        tick_q <= '0;
        if (pre_last) begin
          pre_q <= '0;
          if (div_last) div_q <= '0;
          else          div_q <= div_q + DIV_W'(1);
        end else begin
          pre_q <= pre_q + PRE_W'(1);
        end
      end else begin
        tick_q <= tick_q + TICK_W'(1);
      end
    end
  end
endmodule

// File: rtl/pacer_burst.sv
`timescale 1ns/1ps
// Counts the convert strobes still owed in the current scan.
module pacer_burst #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] count,
  output logic             active
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run)       left_q <= '0;
    else if (load)            left_q <= count;
    else if (step && active)  left_q <= left_q - CNT_W'(1);
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/dual_pacer.sv
`timescale 1ns/1ps
module dual_pacer import pacer_pkg::*; #(
  parameter int CONV_TICK_CYC = 10,
  parameter int SCAN_TICK_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prm_wr,
  input  logic [SLOT_W-1:0] prm_slot,
  input  logic [WORD_W-1:0] prm_data,
  input  logic              start,
  input  logic              stop,
  output logic              cnv_stb,
  output logic              scn_stb
);
  pacer_cfg_t        act_cfg;
  logic [MODE_W-1:0] mode_field;
  logic              run_q, go;
  logic              scan_fire, conv_fire, burst_on;

  assign go = start & ~stop & ~run_q & (mode_field == TRG_INT_RT);

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= (run_q | go) & ~stop;
  end

  pacer_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (prm_wr),
    .wr_slot   (prm_slot),
    .wr_data   (prm_data),
    .capture   (go),
    .act_cfg   (act_cfg),
    .mode_field(mode_field)
  );

  pacer_div #(.TICK_CYC(SCAN_TICK_CYC), .PRE_W(PRE_W), .DIV_W(DIV_W)) u_scan (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (~run_q),
    .en   (run_q),
    .pre  (act_cfg.spre),
    .div  (act_cfg.sdiv),
    .fire (scan_fire)
  );

  pacer_div #(.TICK_CYC(CONV_TICK_CYC), .PRE_W(PRE_W), .DIV_W(DIV_W)) u_conv (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (~run_q | scan_fire),
    .en   (run_q & burst_on),
    .pre  (act_cfg.cpre),
    .div  (act_cfg.cdiv),
    .fire (conv_fire)
  );

  pacer_burst #(.CNT_W(WORD_W)) u_burst (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .load  (scan_fire),
    .step  (conv_fire),
    .count (act_cfg.count),
    .active(burst_on)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scn_stb <= 1'b0;
      cnv_stb <= 1'b0;
    end else begin
      scn_stb <= scan_fire & ~stop;
      cnv_stb <= conv_fire & ~stop;
    end
  end
endmodule

// File: rtl/dual_pacer_chk.sv
`timescale 1ns/1ps
module dual_pacer_chk import pacer_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              stop,
  input logic              scn_stb,
  input logic              cnv_stb,
  input logic              run_q,
  input logic [MODE_W-1:0] mode_field,
  input pacer_cfg_t        act_cfg
);
  logic seen_scan;

  always_ff @(posedge clk) begin
    if (!rst_n)       seen_scan <= 1'b0;
    else if (stop)    seen_scan <= 1'b0;
    else if (scn_stb) seen_scan <= 1'b1;
  end

  assert_scan_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scn_stb |=> !scn_stb);

  assert_conv_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_stb |=> !cnv_stb);

  assert_conv_after_scan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_stb |-> seen_scan);

  assert_bad_mode_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !run_q && mode_field != 3'd2) |=> !run_q);

  assert_restart_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && start) |=> $stable(act_cfg));

  assert_stop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!scn_stb && !cnv_stb));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (!scn_stb && !cnv_stb));
endmodule

bind dual_pacer dual_pacer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .stop      (stop),
  .scn_stb   (scn_stb),
  .cnv_stb   (cnv_stb),
  .run_q     (run_q),
  .mode_field(mode_field),
  .act_cfg   (act_cfg)
);

// File: tb/tb_dual_pacer.sv
`timescale 1ns/1ps
module tb_dual_pacer;
  localparam int CT = 2;
  localparam int ST = 3;
  localparam int LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prm_wr = 1'b0;
  logic [2:0]  prm_slot = '0;
  logic [15:0] prm_data = '0;
  logic        start = 1'b0;
  logic        stop = 1'b0;
  logic        cnv_stb, scn_stb;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  dual_pacer #(.CONV_TICK_CYC(CT), .SCAN_TICK_CYC(ST)) dut (
    .clk(clk), .rst_n(rst_n), .prm_wr(prm_wr), .prm_slot(prm_slot),
    .prm_data(prm_data), .start(start), .stop(stop),
    .cnv_stb(cnv_stb), .scn_stb(scn_stb)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (!done && cyc > LIMIT) begin
      fails++;
      $display("FAIL watchdog all actual=%0d expected<=%0d", cyc, LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic int period(int tick, int pre, int dv);
    return tick * (pre + 1) * ((dv == 0) ? 1 : dv);
  endfunction

  function automatic bit exp_scan(int r, int ps);
    return (r > 0) && (r % ps == 0);
  endfunction

  function automatic bit exp_conv(int r, int ps, int pc, int n);
    for (int j = 1; j <= n; j++) begin
      int d = r - j * pc;
      if (j * pc <= ps && d > 0 && d % ps == 0) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic check(string req, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, got, exp);
    end
  endtask

  task automatic write_slot(int slot, int data);
    @(negedge clk);
    prm_wr = 1'b1; prm_slot = 3'(slot); prm_data = 16'(data);
    @(negedge clk);
    prm_wr = 1'b0;
  endtask

  task automatic quiet(string req, int ncyc);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      check(req, "scan idle", scn_stb, 1'b0);
      check(req, "conv idle", cnv_stb, 1'b0);
    end
  endtask

  // R2: slot map 0 count, 1/2 convert prescale/divider, 3/4 scan, 5 mode bits 4:2
  task automatic run_cfg(int n, int cp, int cd, int sp, int sd, int code,
                         bit wr, int poke, string ovr);
    int pc, ps, win;
    bit live;
    string rs, rc;
    pc = period(CT, cp, cd);
    ps = period(ST, sp, sd);
    win = 3 * ps + 2;
    live = (code == 2);
    rs = (ovr != "") ? ovr : (sd == 0 ? "R4" : "R3");
    rc = (ovr != "") ? ovr : (n * pc > ps ? "R6" : (cd == 0 ? "R4" : "R5"));
    if (!live && ovr == "") begin rs = "R7"; rc = "R7"; end
    if (wr) begin
      write_slot(0, n); write_slot(1, cp); write_slot(2, cd);
      write_slot(3, sp); write_slot(4, sd);
      write_slot(5, 16'h8003 | (code << 2));
    end
    @(negedge clk);
    start = 1'b1;
    for (int r = 0; r <= win; r++) begin
      @(negedge clk);
      start = 1'b0; prm_wr = 1'b0;
      check(rs, $sformatf("scan r=%0d ps=%0d", r, ps), scn_stb,
            live ? exp_scan(r, ps) : 1'b0);
      check(rc, $sformatf("conv r=%0d pc=%0d n=%0d", r, pc, n), cnv_stb,
            live ? exp_conv(r, ps, pc, n) : 1'b0);
      if (r == poke) begin
        start = 1'b1;
        prm_wr = 1'b1; prm_slot = 3'd2; prm_data = 16'd7;
      end
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check("R10", "scan after stop", scn_stb, 1'b0);
    check("R10", "conv after stop", cnv_stb, 1'b0);
    quiet("R10", 4);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "scan in reset", scn_stb, 1'b0);
    check("R1", "conv in reset", cnv_stb, 1'b0);
    rst_n = 1'b1;
    quiet("R1", 5);

    // R3 R4 R5 R6 R7: sweep of settings, mode word with stray bits set
    for (int cp = 0; cp < 2; cp++)
      for (int cd = 0; cd < 4; cd++)
        for (int n = 0; n < 4; n++)
          for (int sp = 0; sp < 2; sp++)
            for (int sdi = 0; sdi < 2; sdi++)
              run_cfg(n, cp, cd, sp, sdi * 3, 2, 1'b1, -1, "");

    // R7: other trigger codes stay idle
    run_cfg(2, 0, 1, 1, 2, 0, 1'b1, -1, "R7");
    run_cfg(2, 0, 1, 1, 2, 1, 1'b1, -1, "R7");
    run_cfg(2, 0, 1, 1, 2, 3, 1'b1, -1, "R7");
    run_cfg(2, 0, 1, 1, 2, 4, 1'b1, -1, "R7");
    run_cfg(2, 0, 1, 1, 2, 7, 1'b1, -1, "R7");

    // R8: start pulse and divider write mid-run leave timing untouched
    run_cfg(2, 0, 2, 1, 5, 2, 1'b1, 11, "R8");
    // R9: the divider written during the last run applies at this start
    run_cfg(2, 0, 7, 1, 5, 2, 1'b0, -1, "R9");

    // R2: count slot rewritten alone, other slots kept
    write_slot(0, 1);
    run_cfg(1, 0, 7, 1, 5, 2, 1'b0, -1, "R2");

    // R10: start together with stop stays idle
    write_slot(0, 1); write_slot(1, 0); write_slot(2, 1);
    write_slot(3, 0); write_slot(4, 1); write_slot(5, 2 << 2);
    @(negedge clk);
    start = 1'b1; stop = 1'b1;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    quiet("R10", 20);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule